// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM Datapath

This block is the storage and data path of a synchronous single-port memory whose 36-bit words are split into four 9-bit byte lanes. On each rising clock edge it captures the chip select, the word address, the write data and the write controls. It then decodes them into one of three operations: idle, read or write. A write lands in the array on the following edge. A global-write strobe can force all four lanes to be written. Otherwise a common write enable, qualified by active-low per-lane selects, picks the lanes to store.

A read looks up the array in the cycle after its controls were captured. The word is loaded into an output register on the next edge, so read data appears on the output two edges after the request. The output driver is enabled by an unclocked, active-low output enable ANDed with a registered "read data present" flag. That flag drops after a single deselect or write cycle. The word address is supplied from outside, usually by a burst sequencer. The high-impedance state of the bus is modelled by the `dout_en` pin.

Top module: `bwsram_pipe`

## Requirements
- R1: When `gw_n` is sampled low with `ce` high, all four lanes at the sampled address are stored from `din`, whatever the values of `we_n` and `bsel_n`.
- R2: When `gw_n` is high, `we_n` is low and at least one bit of `bsel_n` is low, only the lanes whose select bit is low are stored. Lane i is `din[9*i+8:9*i]` and is selected by `bsel_n[i]`, so lane a is bits 8:0 and lane d is bits 35:27. All other lanes keep their old contents, and all bits low writes every lane.
- R3: `gw_n` high with `we_n` low and all four `bsel_n` bits high is a read, not a write, and leaves the array unchanged.
- R4: For a read whose controls are sampled at edge k, `dout` carries the addressed word and `dout_en` is high (with `oe_n` low) from edge k+1 until edge k+2.
- R5: A read sampled on the edge right after a write to the same address returns the newly written lanes.
- R6: `dout_en` is never high while `oe_n` is high, and a change of `oe_n` changes `dout_en` with no clock edge.
- R7: A cycle sampled with `ce` low at edge k performs no array access, and `dout_en` is low from edge k+1 (single-cycle deselect).
- R8: For a write sampled at edge k, `dout_en` is low from edge k+1 until edge k+2.
- R9: While `rst_n` is low and after it is released, `dout_en` stays low until a read has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| ce | input | 1 | Chip select, active high, sampled |
| addr | input | AW | Word address, sampled |
| gw_n | input | 1 | Global write, active low, sampled |
| we_n | input | 1 | Common write enable for the lane selects, active low, sampled |
| bsel_n | input | LANES | Per-lane selects, active low, sampled; bit i is lane i |
| din | input | LANES*LANE_W | Write data, sampled |
| oe_n | input | 1 | Output enable, active low, not sampled by the clock |
| dout | output | LANES*LANE_W | Output register contents |
| dout_en | output | 1 | High when the output bus is driven; low stands for high impedance |

## Verification
The hardest situation to reach is a partial-lane write followed, on the very next edge, by a read of the same word. That read checks lane merging and the one-cycle write-to-read ordering in a single result. The stimulus first fills every word with a known pattern using global writes. It then issues single-lane and multi-lane writes, each immediately followed by a read of the same address. Between clock edges it also toggles the output enable, and it places deselect and write cycles directly after reads, so the one-cycle release of the output can be seen.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int NLANES    = 4;
  localparam int LANE_BITS = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bw_op_e;
endpackage

// File: rtl/bwsram_inreg.sv
module bwsram_inreg
  import bwsram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = NLANES,
  parameter int DW    = NLANES * LANE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [AW-1:0]    addr,
  input  logic             gw_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic [DW-1:0]    din,
  output bw_op_e           op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] lane_we_q,
  output logic [DW-1:0]    din_q
);
  logic             any_lane;
  logic             is_write;
  logic [LANES-1:0] lane_mask;
  bw_op_e           op_d;

  always_comb begin
    any_lane  = ~(&bsel_n);
    is_write  = ~gw_n | (~we_n & any_lane);
    lane_mask = gw_n ? ~bsel_n : {LANES{1'b1}};
    if (!ce)          op_d = OP_IDLE;
    else if (is_write) op_d = OP_WRITE;
    else              op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      lane_we_q <= '0;
    end else begin
      op_q      <= op_d;
      lane_we_q <= (op_d == OP_WRITE) ? lane_mask : '0;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr;
    din_q  <= din;
  end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr && lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/bwsram_outreg.sv
module bwsram_outreg #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] rdata,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= load;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= rdata;
  end

  assign dout_en = held & ~oe_n;
endmodule

// File: rtl/bwsram_pipe.sv
module bwsram_pipe
  import bwsram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = NLANES,
  parameter int LANE_W = LANE_BITS,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [AW-1:0]    addr,
  input  logic             gw_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic [DW-1:0]    din,
  input  logic             oe_n,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);
  bw_op_e           op_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] lane_we_q;
  logic [DW-1:0]    din_q;
  logic [DW-1:0]    arr_rd;

  bwsram_inreg #(.AW(AW), .LANES(LANES), .DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .gw_n(gw_n),
    .we_n(we_n), .bsel_n(bsel_n), .din(din), .op_q(op_q),
    .addr_q(addr_q), .lane_we_q(lane_we_q), .din_q(din_q)
  );

  bwsram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .wr(op_q == OP_WRITE), .addr(addr_q), .lane_we(lane_we_q),
    .wdata(din_q), .rdata(arr_rd)
  );

  bwsram_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(op_q == OP_READ), .rdata(arr_rd),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/bwsram_pipe_chk.sv
module bwsram_pipe_chk #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic [AW-1:0]    addr,
  input logic             gw_n,
  input logic             we_n,
  input logic [LANES-1:0] bsel_n,
  input logic [DW-1:0]    din,
  input logic             oe_n,
  input logic [DW-1:0]    dout,
  input logic             dout_en
);
  logic was_rd;
  logic was_wr;
  assign was_rd = ce & gw_n & (we_n | (&bsel_n));
  assign was_wr = ce & ~was_rd;

  // R6: output never driven while output enable is high
  a_r6_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R7: deselect two edges back means nothing is driven now
  a_r7_single_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce, 2) |-> !dout_en);

  // R8: a write cycle leaves the bus undriven
  a_r8_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(was_wr, 2) && $past(rst_n, 2) && $past(rst_n)) |-> !dout_en);

  // R4: a read sampled two edges back drives the bus when enabled
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(was_rd, 2) && $past(rst_n, 2) && $past(rst_n) && !oe_n) |-> dout_en);

  // R4: the driven word does not change between edges without a new read
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(was_rd, 2) && $past(dout_en) && dout_en) |-> $stable(dout));
endmodule

bind bwsram_pipe bwsram_pipe_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (.*);

// File: tb/test_bwsram_pipe.sv
`timescale 1ns/1ps
module test_bwsram_pipe;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1;
  logic          we_n = 1'b1;
  logic [3:0]    bsel_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic          oe_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #4 clk = ~clk;

  bwsram_pipe i_bwsram_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .gw_n(gw_n), .we_n(we_n),
    .bsel_n(bsel_n), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  // reference model
  logic [DW-1:0] mm [DEPTH];
  int            s_kind;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] s_addr;
  logic [3:0]    s_mask;
  logic [DW-1:0] s_data;
  logic          m_valid;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_kind  = 0;
      m_valid = 1'b0;
    end else begin
      if (s_kind == 2)
        for (int l = 0; l < 4; l++)
          if (s_mask[l]) mm[s_addr][l*9 +: 9] = s_data[l*9 +: 9];
      m_valid = (s_kind == 1);
      if (s_kind == 1) m_data = mm[s_addr];
      if (!ce) s_kind = 0;
      else if (!gw_n || (!we_n && bsel_n != 4'hF)) s_kind = 2;
      else s_kind = 1;
      s_mask = !gw_n ? 4'hF : ~bsel_n;
      s_addr = addr;
      s_data = din;
    end
  end

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string tag = "R9";

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic compare();
    logic e_en;
    e_en = m_valid && !oe_n;
    chk({tag, " dout_en"}, {35'd0, dout_en}, {35'd0, e_en});
    if (e_en) chk({tag, " dout"}, dout, m_data);
  endtask

  // one clock: compare at the negative edge, then apply new inputs
  task automatic step(input logic c, input logic [AW-1:0] a, input logic g,
                      input logic w, input logic [3:0] b, input logic [DW-1:0] d,
                      input logic o);
    @(negedge clk);
    compare();
    ce = c; addr = a; gw_n = g; we_n = w; bsel_n = b; din = d; oe_n = o;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b1, a, 1'b1, 1'b1, 4'h0, '0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b1, 1'b1, 4'hF, '0, 1'b0);
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  initial begin
    // R9: reset state
    repeat (3) step(1'b1, 4'd0, 1'b1, 1'b1, 4'h0, '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    compare();
    idle(); idle();

    // R1: fill every word with global writes, lane selects random
    tag = "R1";
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, AW'(i), 1'b0, i[0], 4'($urandom()), rnd(), 1'b0);
    idle();
    for (int i = 0; i < DEPTH; i++) rd(AW'(i));
    idle(); idle();

    // R2: single-lane writes, then mixed masks, each read back at once
    tag = "R2";
    for (int l = 0; l < 4; l++) begin
      step(1'b1, AW'(l + 2), 1'b1, 1'b0, ~(4'b1 << l), rnd(), 1'b0);
      rd(AW'(l + 2));
    end
    step(1'b1, 4'd9, 1'b1, 1'b0, 4'b0101, rnd(), 1'b0);
    rd(4'd9);
    step(1'b1, 4'd10, 1'b1, 1'b0, 4'b0000, rnd(), 1'b0);
    rd(4'd10);
    idle(); idle();

    // R3: write enable low with no lane selected is a read
    tag = "R3";
    step(1'b1, 4'd5, 1'b1, 1'b0, 4'hF, rnd(), 1'b0);
    step(1'b1, 4'd6, 1'b1, 1'b0, 4'hF, rnd(), 1'b0);
    rd(4'd5); rd(4'd6);
    idle(); idle();

    // R5: write then read of the same word on the next edge
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, AW'(i + 7), 1'b1, 1'b0, 4'($urandom()) | 4'b0001 ^ 4'b0001, rnd(), 1'b0);
      rd(AW'(i + 7));
    end
    idle(); idle();

    // R4: back-to-back reads, enable held
    tag = "R4";
    for (int i = 0; i < 8; i++) rd(AW'(15 - i));
    idle(); idle();

    // R6: output enable changed between edges, no clock
    tag = "R6";
    rd(4'd3);
    step(1'b0, '0, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    @(posedge clk);
    #1;
    chk("R6 driven before oe change", {35'd0, dout_en}, 36'd1);
    oe_n = 1'b1; #1;
    chk("R6 float after oe high", {35'd0, dout_en}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R6 driven after oe low", {35'd0, dout_en}, 36'd1);
    chk("R6 data", dout, mm[3]);
    step(1'b1, 4'd4, 1'b1, 1'b1, 4'h0, '0, 1'b1);
    idle();

    // R7: deselect right after a read frees the bus after one cycle
    tag = "R7";
    rd(4'd8);
    idle();
    idle();
    // R7: deselected write does not store
    step(1'b0, 4'd8, 1'b0, 1'b0, 4'h0, rnd(), 1'b0);
    idle();
    rd(4'd8);
    idle(); idle();

    // R8: write cycle between reads floats the bus
    tag = "R8";
    rd(4'd1);
    step(1'b1, 4'd2, 1'b0, 1'b1, 4'hF, rnd(), 1'b0);
    rd(4'd2);
    step(1'b1, 4'd11, 1'b1, 1'b0, 4'b1110, rnd(), 1'b0);
    rd(4'd11);
    idle(); idle(); idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule